// File: doc/BRIEF.md
# Pulse Zero-Crossing Interval Timer

This block sits behind a sampled receiver for a pulsed radio-navigation signal whose pulses ride on a 100 kHz carrier. Signed samples arrive at 1 MHz (about ten per carrier cycle), each marked by a one-cycle valid strobe. When a sample's magnitude exceeds a programmable threshold, the block treats it as the start of a pulse. It then counts negative-to-positive carrier crossings and takes the third one as the pulse's timing reference.

A free-running sample counter measures the interval between the timing references of successive pulses. At each reference the counter value is copied into a holding register, the counter restarts, and an interrupt is raised to a host processor. The host reads the interval through a two-address register port and acknowledges the interrupt there. A reference that arrives while an interrupt is still pending sets a sticky overrun flag. Two controls keep a pulse from being counted twice or from locking the block up. A blanking window after each reference ignores the tail of the same pulse. A timeout abandons a pulse whose third crossing does not come in time.

Top module: `zc_interval_timer`

## Requirements
- R1: After reset, irq_o is 0, address 0 reads 0 and address 1 reads 0.
- R2: In the idle state, a valid sample whose magnitude (two's complement absolute value) is strictly greater than thresh_i starts a pulse. A magnitude equal to or below thresh_i starts nothing.
- R3: A rising crossing is a valid sample with sign bit 0 whose previous valid sample had sign bit 1. Only rising crossings on samples after the onset sample are counted. Positive-to-negative changes are never counted.
- R4: The third counted rising crossing is the reference. On the clock edge that takes that sample, the interval is loaded into the holding register and irq_o goes to 1. The holding register changes at no other time.
- R5: The latched interval equals the number of valid samples after the previous reference, up to and including the current reference sample. The first reference after reset counts from reset. Cycles without smp_valid_i do not count, and the count wraps modulo 2^CNT_W.
- R6: If the third crossing has not arrived by the timeout_len_i-th valid sample after onset, the block returns to idle at that sample and latches nothing. A third crossing on exactly that sample is still a reference.
- R7: After a reference, the next max(blank_len_i,1) valid samples cannot start a pulse. The sample after them can.
- R8: Reads are combinational. Address 0 returns the held interval. Address 1 returns the pending interrupt in bit 0 and the overrun flag in bit 1, with zeros above.
- R9: A write to address 1 with data bit 0 set clears irq_o on the next edge, and one with bit 1 set clears the overrun flag. A reference in the same cycle as the acknowledge keeps irq_o at 1.
- R10: A reference that arrives while irq_o is 1, with no acknowledge in that cycle, sets the overrun flag. The flag stays set until it is cleared through R9, and the holding register takes the newer interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe, one cycle per sample |
| smp_i | input | SAMPLE_W | Signed sample |
| thresh_i | input | SAMPLE_W | Onset magnitude threshold |
| timeout_len_i | input | TO_W | Samples allowed from onset to third crossing |
| blank_len_i | input | BL_W | Samples ignored after a reference |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address |
| reg_wdata_i | input | 2 | Write data: bit 0 acknowledge, bit 1 clear overrun |
| reg_rdata_o | output | CNT_W | Read data |
| irq_o | output | 1 | Interrupt, held until acknowledged |

## Verification
A crossing counter that is off by one moves the reference by a whole carrier cycle. This shows at address 0 as an interval wrong by ten samples, and irq_o rises ten samples early or late, on the first pulse after reset. A wrong idle, blanking or timeout state shows up as a missing or extra interrupt within one pulse of the stimulus: a second reference inside a long pulse, or no reference at the timeout boundary. The bench sweeps carrier polarity, amplitude around the threshold, inter-pulse gaps and the exact timeout and blanking boundaries. It predicts every reference sample index arithmetically from the waveform it generates.

// File: rtl/zcit_pkg.sv
package zcit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_CROSS1 = 3'd2,
    ST_CROSS2 = 3'd3,
    ST_BLANK  = 3'd4
  } zc_state_e;
endpackage

// File: rtl/zcit_edge.sv
module zcit_edge #(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [SAMPLE_W-1:0] thresh_i,
  output logic                       onset_o,
  output logic                       rise_o
);
  logic                prev_neg_q;
  logic [SAMPLE_W-1:0] mag;

  // most negative value maps to 2^(SAMPLE_W-1) as unsigned
  assign mag     = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
  assign onset_o = valid_i && (mag > thresh_i);
  assign rise_o  = valid_i && prev_neg_q && !sample_i[SAMPLE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_neg_q <= 1'b0;
    else if (valid_i) prev_neg_q <= sample_i[SAMPLE_W-1];
  end
endmodule

// File: rtl/zcit_seq.sv
module zcit_seq
  import zcit_pkg::*;
#(
  parameter int TO_W = 8,
  parameter int BL_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            onset_i,
  input  logic            rise_i,
  input  logic [TO_W-1:0] timeout_len_i,
  input  logic [BL_W-1:0] blank_len_i,
  output logic            ref_o,
  output zc_state_e       state_o
);
  localparam int CW = (TO_W > BL_W) ? TO_W : BL_W;

  zc_state_e     state_q, state_d;
  logic [CW-1:0] age_q, age_d;
  logic [CW:0]   age_inc;
  logic [CW:0]   to_lim, bl_lim;

  assign age_inc = {1'b0, age_q} + 1'b1;
  assign to_lim  = (CW+1)'(timeout_len_i);
  assign bl_lim  = (CW+1)'(blank_len_i);

  always_comb begin
    state_d = state_q;
    age_d   = age_q;
    ref_o   = 1'b0;
    if (valid_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (onset_i) begin
            state_d = ST_ARMED;
            age_d   = '0;
          end
        end
        ST_ARMED, ST_CROSS1, ST_CROSS2: begin
          if (rise_i && state_q == ST_CROSS2) begin
            ref_o   = 1'b1;
            state_d = ST_BLANK;
            age_d   = '0;
          end else begin
            age_d = age_inc[CW-1:0];
            if (rise_i) state_d = (state_q == ST_ARMED) ? ST_CROSS1 : ST_CROSS2;
            if (age_inc >= to_lim) state_d = ST_IDLE;
          end
        end
        ST_BLANK: begin
          age_d = age_inc[CW-1:0];
          if (age_inc >= bl_lim) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      age_q   <= '0;
    end else begin
      state_q <= state_d;
      age_q   <= age_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/zcit_ctr.sv
module zcit_ctr #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ref_i,
  output logic [CNT_W-1:0] hold_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_o <= '0;
    end else if (valid_i) begin
      if (ref_i) begin
        hold_o <= cnt_q + 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/zcit_irq.sv
module zcit_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic       we_i,
  input  logic       addr_i,
  input  logic [1:0] wdata_i,
  output logic       irq_o,
  output logic       ovr_o
);
  logic ack, clr;

  assign ack = we_i && addr_i && wdata_i[0];
  assign clr = we_i && addr_i && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      ovr_o <= 1'b0;
    end else begin
      if (ref_i)    irq_o <= 1'b1;
      else if (ack) irq_o <= 1'b0;
      if (ref_i && irq_o && !ack) ovr_o <= 1'b1;
      else if (clr)               ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/zc_interval_timer.sv
module zc_interval_timer
  import zcit_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 24,
  parameter int TO_W     = 8,
  parameter int BL_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       smp_valid_i,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic        [SAMPLE_W-1:0] thresh_i,
  input  logic        [TO_W-1:0]     timeout_len_i,
  input  logic        [BL_W-1:0]     blank_len_i,
  input  logic                       reg_we_i,
  input  logic                       reg_addr_i,
  input  logic        [1:0]          reg_wdata_i,
  output logic        [CNT_W-1:0]    reg_rdata_o,
  output logic                       irq_o
);
  logic             onset, rise, ref_pulse, ovr;
  zc_state_e        state;
  logic [CNT_W-1:0] hold;

  zcit_edge #(.SAMPLE_W(SAMPLE_W)) u_edge (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .sample_i(smp_i),
    .thresh_i, .onset_o(onset), .rise_o(rise)
  );

  zcit_seq #(.TO_W(TO_W), .BL_W(BL_W)) u_seq (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .onset_i(onset), .rise_i(rise),
    .timeout_len_i, .blank_len_i, .ref_o(ref_pulse), .state_o(state)
  );

  zcit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .ref_i(ref_pulse), .hold_o(hold)
  );

  zcit_irq u_irq (
    .clk_i, .rst_ni, .ref_i(ref_pulse), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .irq_o, .ovr_o(ovr)
  );

  assign reg_rdata_o = reg_addr_i ? {{(CNT_W-2){1'b0}}, ovr, irq_o} : hold;
endmodule

// File: rtl/zcit_chk.sv
module zcit_chk
  import zcit_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_valid_i,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic [1:0]       reg_wdata_i,
  input logic             irq_o,
  input logic             ovr_i,
  input logic             ref_i,
  input zc_state_e        state_i,
  input logic [CNT_W-1:0] hold_i
);
  assert_ref_from_cross2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_i |-> (state_i == ST_CROSS2 && smp_valid_i));

  assert_irq_on_ref_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_i |=> irq_o);

  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_i |=> $stable(hold_i));

  assert_blank_no_arm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_BLANK) |=> (state_i != ST_ARMED));

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i && reg_wdata_i[0] && !ref_i) |=> !irq_o);

  assert_ovr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !(reg_we_i && reg_addr_i && reg_wdata_i[1])) |=> ovr_i);

  assert_ovr_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> ($past(ref_i) && $past(irq_o)));
endmodule

bind zc_interval_timer zcit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .smp_valid_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .irq_o, .ovr_i(ovr), .ref_i(ref_pulse), .state_i(state), .hold_i(hold)
);

// File: tb/zc_interval_timer_test.sv
module zc_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] smp = '0;
  logic [11:0] thresh = 12'd100;
  logic [7:0]  tmo = 8'd45;
  logic [7:0]  blank = 8'd40;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [1:0]  wdata = '0;
  logic [23:0] rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  int idx = 0, last_ref = -1, held = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zc_interval_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_i(smp),
    .thresh_i(thresh), .timeout_len_i(tmo), .blank_len_i(blank),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input bit a, output int v);
    addr = a;
    #1 v = int'(rdata);
    addr = 1'b0;
  endtask

  task automatic wr(input int d);
    @(negedge clk);
    we = 1'b1; addr = 1'b1; wdata = 2'(d);
    @(negedge clk);
    we = 1'b0; addr = 1'b0; wdata = '0;
  endtask

  task automatic push(input int v);
    @(negedge clk);
    valid = 1'b1; smp = 12'(v);
    @(negedge clk);
    valid = 1'b0;
    idx++;
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) begin
      push(0);
      if (i % 2 == 1) @(negedge clk);  // gap without valid
    end
  endtask

  // carrier of period 10: five samples of one sign, five of the other
  task automatic pulse(input int len, input int amp, input bit neg_first,
                       input int off1, input int off2, input string req);
    int v, r;
    for (int j = 0; j < len; j++) begin
      v = ((((j % 10) < 5) ? 1'b1 : 1'b0) ^ neg_first) ? amp : -amp;
      if (j == off1 || j == off2) begin
        r = idx;
        push(v);
        held = r - last_ref;
        last_ref = r;
        rd(1'b0, v);
        chk({req, " R4/R5 interval at reference"}, v, held);
        chk({req, " R4 irq at reference"}, int'(irq), 1);
      end else if (j + 1 == off1 || j + 1 == off2) begin
        push(v);
        rd(1'b0, v);
        chk({req, " R4 hold unchanged before reference"}, v, held);
      end else begin
        push(v);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", int'(irq), 0);
    rd(1'b0, v); chk("R1 interval after reset", v, 0);
    rd(1'b1, v); chk("R1 status after reset", v, 0);

    zeros(20);

    // main sweep over polarity, amplitude, gap; R3: negative-first gives 25
    for (int k = 0; k < 6; k++) begin
      bit nf = k[0];
      pulse(35, 150 + k * 310, nf, nf ? 25 : 30, -1, nf ? "R3 neg-first" : "R3 pos-first");
      rd(1'b1, v); chk("R8 status pending", v, 1);
      wr(1);
      chk("R9 ack clears irq", int'(irq), 0);
      rd(1'b1, v); chk("R9 status after ack", v, 0);
      zeros(40 + k * 23);
    end

    // R2: magnitude at or below threshold never starts a pulse
    for (int a = 98; a <= 100; a++) begin
      pulse(35, a, a[0], -1, -1, "R2");
      zeros(60);
      chk("R2 no irq at or below threshold", int'(irq), 0);
      rd(1'b0, v); chk("R2 hold unchanged", v, held);
    end
    pulse(35, 101, 1'b1, 25, -1, "R2 above threshold");
    wr(1);
    zeros(60);

    // R6: timeout boundary
    tmo = 8'd29;
    pulse(35, 500, 1'b0, -1, -1, "R6");
    zeros(60);
    chk("R6 timeout 29 gives no irq", int'(irq), 0);
    rd(1'b0, v); chk("R6 hold unchanged after timeout", v, held);
    tmo = 8'd30;
    pulse(35, 500, 1'b0, 30, -1, "R6 timeout 30");
    wr(1);
    zeros(60);

    // R7/R10: short blanking retriggers inside a long pulse
    blank = 8'd2;
    pulse(75, 500, 1'b0, 30, 60, "R7 short blank");
    rd(1'b1, v); chk("R10 overrun and irq set", v, 3);
    wr(1);
    rd(1'b1, v); chk("R10 overrun sticky after ack", v, 2);
    wr(2);
    rd(1'b1, v); chk("R9 clear overrun", v, 0);
    zeros(60);

    blank = 8'd40;
    pulse(75, 500, 1'b0, 30, -1, "R7 long blank");
    zeros(60);
    rd(1'b1, v); chk("R7 single reference, no overrun", v, 1);
    rd(1'b0, v); chk("R7 hold keeps single interval", v, held);
    wr(1);
    zeros(50);
    pulse(35, 700, 1'b1, 25, -1, "R5 final interval");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule